// File: doc/BRIEF.md
# DRAM Compressed Test Mode Controller

This block is a synthesizable behavioural model of the test logic inside one byte-wide DRAM device. The active-low row strobe, column strobe, write enable and output enable are sampled on a system clock. The block sorts each row-strobe falling edge into one of three kinds: a refresh with write enable low (which arms the test mode), a plain column-before-row refresh, or an ordinary row cycle. It keeps a refresh row counter and a latched test-mode flag. A reduced array sits behind a multiplexed address. The row goes in on the row-strobe fall and the column on each column-strobe fall.

In normal mode an early write stores the byte at the addressed cell, and a read returns it one clock after the column strobe is sampled low. In test mode the top column bit is ignored, so each data pin covers two cells that differ only in that bit. A write stores the pin's value into both cells. A read reports, per pin, a one when the two cells agree and a zero when they differ. That result arrives one clock later than a normal read. Test mode ends on a plain column-before-row refresh, or on a row cycle that closes without any column strobe.

The data port is split into input, output and output-enable signals. The output enable is off whenever the column strobe or the output enable is high, and during an early write.

Top module: `dtm_core`

## Requirements
- R1: While reset is high, and right after it, tm_active is 0, dq_oe is 0 and rfsh_row is 0.
- R2: A row-strobe fall sampled with the column strobe and write enable both low sets tm_active from the next clock and advances rfsh_row by one.
- R3: Once set, tm_active stays 1 through any number of normal read and write cycles.
- R4: A row-strobe fall sampled with the column strobe low and write enable high clears tm_active and advances rfsh_row by one, wrapping modulo 2^ROW_BITS.
- R5: A row cycle that ends (row strobe sampled high again) with no column-strobe fall clears tm_active and leaves rfsh_row unchanged.
- R6: In normal mode an early write (write enable low when the column strobe fall is sampled) stores dq_in at (row, column). A read drives that byte on dq_out with dq_oe high from the clock edge that samples the column strobe low.
- R7: In test mode a write stores dq_in into both cells of the addressed row whose column differs only in the top column bit (bit COL_BITS-1).
- R8: In test mode a read ignores the top column bit. Each bit i of dq_out is 1 if bit i of the two paired cells is equal and 0 otherwise.
- R9: A test-mode read keeps dq_oe low at the first clock edge after the column strobe fall is sampled, and drives valid data from the edge after that.
- R10: dq_oe is 0 whenever the column strobe or output enable is high, and throughout an early write.
- R11: A refresh cycle of either kind changes no array contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Multiplexed row / column address |
| dq_in | input | DW | Write data from the pins |
| dq_out | output | DW | Read data to the pins |
| dq_oe | output | 1 | Drive enable for dq_out |
| tm_active | output | 1 | Test mode latched |
| rfsh_row | output | ROW_BITS | Internal refresh row counter |

## Verification
The hardest case to reach is a compressed read that sees a mix of agreeing and disagreeing bits across every pair, together with the one-clock delay. The array must first hold contents where the two halves of each pair differ by a known, varying mask. The stimulus fills every cell in normal mode with an arithmetic pattern. It then arms test mode with a write-enable-low refresh and sweeps all columns of every row, both halves of each pair. After test-mode pair writes, a plain refresh ends the mode, and a full normal read-back shows that both cells took the value and that the refreshes left the data alone.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    // Kind of the cycle opened by the last row-strobe fall
    typedef enum logic [1:0] {
        CYC_IDLE = 2'd0,
        CYC_ROW  = 2'd1,
        CYC_REF  = 2'd2
    } cyc_e;

    // Edge events seen on the sampled strobes
    typedef struct packed {
        logic ras_fall;
        logic ras_rise;
        logic cas_fall;
    } strb_ev_t;

    // Per-bit pair agreement: one where the two cells match
    function automatic logic [7:0] pair_agree8(input logic [7:0] a, input logic [7:0] b);
        return ~(a ^ b);
    endfunction

endpackage

// File: rtl/dtm_strobe_decode.sv
module dtm_strobe_decode
    import dtm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ras_n,
    input  logic     cas_n,
    output strb_ev_t ev
);
    logic ras_q;
    logic cas_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ras_q <= 1'b1;
            cas_q <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
        end
    end

    always_comb begin
        ev.ras_fall = ras_q & ~ras_n;
        ev.ras_rise = ~ras_q & ras_n;
        ev.cas_fall = cas_q & ~cas_n;
    end
endmodule

// File: rtl/dtm_mode_ctl.sv
module dtm_mode_ctl
    import dtm_pkg::*;
#(
    parameter int ROW_BITS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  strb_ev_t            ev,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic [ROW_BITS-1:0] row_addr,
    output logic                tm,
    output logic [ROW_BITS-1:0] row,
    output logic [ROW_BITS-1:0] rcnt,
    output logic                col_evt
);
    cyc_e cyc;
    logic col_seen;

    // A column access only counts inside an open row cycle
    assign col_evt = ev.cas_fall && !ras_n && (cyc == CYC_ROW);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc      <= CYC_IDLE;
            tm       <= 1'b0;
            col_seen <= 1'b0;
            rcnt     <= '0;
            row      <= '0;
        end else if (ev.ras_fall) begin
            col_seen <= 1'b0;
            if (!cas_n) begin
                cyc  <= CYC_REF;
                tm   <= !we_n;
                rcnt <= rcnt + 1'b1;
            end else begin
                cyc <= CYC_ROW;
                row <= row_addr;
            end
        end else if (ev.ras_rise) begin
            if (cyc == CYC_ROW && !col_seen)
                tm <= 1'b0;
            cyc <= CYC_IDLE;
        end else if (col_evt) begin
            col_seen <= 1'b1;
        end
    end
endmodule

// File: rtl/dtm_array.sv
module dtm_array
    import dtm_pkg::*;
#(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 4,
    parameter int DW       = 8
) (
    input  logic                clk,
    input  logic                wr_en,
    input  logic                tm,
    input  logic [ROW_BITS-1:0] row,
    input  logic [COL_BITS-1:0] col,
    input  logic [DW-1:0]       din,
    output logic [DW-1:0]       rd_norm,
    output logic [DW-1:0]       rd_cmp
);
    localparam int IW    = ROW_BITS + COL_BITS;
    localparam int DEPTH = 1 << IW;

    logic [DW-1:0] mem [DEPTH];
    logic [IW-1:0] idx_n;
    logic [IW-1:0] idx_lo;
    logic [IW-1:0] idx_hi;

    always_comb begin
        idx_n  = {row, col};
        idx_lo = {row, 1'b0, col[COL_BITS-2:0]};
        idx_hi = {row, 1'b1, col[COL_BITS-2:0]};
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (tm) begin
                mem[idx_lo] <= din;
                mem[idx_hi] <= din;
            end else begin
                mem[idx_n] <= din;
            end
        end
    end

    assign rd_norm = mem[idx_n];

    generate
        if (DW == 8) begin : g_cmp8
            assign rd_cmp = pair_agree8(mem[idx_lo], mem[idx_hi]);
        end else begin : g_cmpn
            assign rd_cmp = ~(mem[idx_lo] ^ mem[idx_hi]);
        end
    endgenerate
endmodule

// File: rtl/dtm_core.sv
module dtm_core
    import dtm_pkg::*;
#(
    parameter int ROW_BITS = 2,
    parameter int COL_BITS = 4,
    parameter int DW       = 8,
    localparam int AW      = (COL_BITS > ROW_BITS) ? COL_BITS : ROW_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ras_n,
    input  logic                cas_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [AW-1:0]       addr,
    input  logic [DW-1:0]       dq_in,
    output logic [DW-1:0]       dq_out,
    output logic                dq_oe,
    output logic                tm_active,
    output logic [ROW_BITS-1:0] rfsh_row
);
    strb_ev_t            ev;
    logic                tm;
    logic                col_evt;
    logic [ROW_BITS-1:0] row;
    logic [DW-1:0]       rd_norm;
    logic [DW-1:0]       rd_cmp;
    logic [DW-1:0]       acc;
    logic                rdy;
    logic                pend;
    logic                ewr;

    dtm_strobe_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .ev    (ev)
    );

    dtm_mode_ctl #(.ROW_BITS(ROW_BITS)) u_mode (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .we_n     (we_n),
        .row_addr (addr[ROW_BITS-1:0]),
        .tm       (tm),
        .row      (row),
        .rcnt     (rfsh_row),
        .col_evt  (col_evt)
    );

    dtm_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DW(DW)) u_arr (
        .clk     (clk),
        .wr_en   (col_evt && !we_n),
        .tm      (tm),
        .row     (row),
        .col     (addr[COL_BITS-1:0]),
        .din     (dq_in),
        .rd_norm (rd_norm),
        .rd_cmp  (rd_cmp)
    );

    // Output stage: normal reads land at once, compressed reads wait one more edge
    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            rdy  <= 1'b0;
            pend <= 1'b0;
            ewr  <= 1'b0;
        end else if (cas_n || ras_n) begin
            rdy  <= 1'b0;
            pend <= 1'b0;
            ewr  <= 1'b0;
        end else if (col_evt) begin
            if (!we_n) begin
                ewr  <= 1'b1;
                rdy  <= 1'b0;
                pend <= 1'b0;
            end else begin
                acc  <= tm ? rd_cmp : rd_norm;
                rdy  <= !tm;
                pend <= tm;
                ewr  <= 1'b0;
            end
        end else if (pend) begin
            rdy  <= 1'b1;
            pend <= 1'b0;
        end
    end

    assign dq_out    = acc;
    assign dq_oe     = rdy && !cas_n && !oe_n && !ewr;
    assign tm_active = tm;
endmodule

// File: rtl/dtm_core_chk.sv
module dtm_core_chk #(
    parameter int ROW_BITS = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                ras_n,
    input logic                cas_n,
    input logic                we_n,
    input logic                dq_oe,
    input logic                tm_active,
    input logic [ROW_BITS-1:0] rfsh_row
);
    p_reset_r1: assert property (@(posedge clk) rst |=> (!tm_active && !dq_oe && rfsh_row == '0));

    p_enter_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(ras_n) && !ras_n && !cas_n && !we_n) |=> tm_active);

    p_rfsh_r2: assert property (@(posedge clk) disable iff (rst)
        ($past(ras_n) && !ras_n && !cas_n) |=> (rfsh_row == ROW_BITS'($past(rfsh_row) + 1'b1)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (ras_n == $past(ras_n)) |=> $stable(tm_active));

    p_exit_cbr_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(ras_n) && !ras_n && !cas_n && we_n) |=> !tm_active);

    p_cnt_still_r5: assert property (@(posedge clk) disable iff (rst)
        !($past(ras_n) && !ras_n && !cas_n) |=> $stable(rfsh_row));

    p_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (tm_active && $past(cas_n) && !cas_n && we_n) |=> !dq_oe);

    p_ewrite_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(cas_n) && !cas_n && !we_n && !ras_n) |=> !dq_oe);
endmodule

bind dtm_core dtm_core_chk #(.ROW_BITS(ROW_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .dq_oe     (dq_oe),
    .tm_active (tm_active),
    .rfsh_row  (rfsh_row)
);

// File: tb/dtm_core_test.sv
module dtm_core_test;
    localparam int CLK_P    = 10;
    localparam int ROW_BITS = 2;
    localparam int COL_BITS = 4;
    localparam int DW       = 8;
    localparam int AW       = 4;
    localparam int NR       = 1 << ROW_BITS;
    localparam int NC       = 1 << COL_BITS;
    localparam int HC       = NC / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic dq_oe, tm_active;
    logic [ROW_BITS-1:0] rfsh_row;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int rc = 0;
    logic [7:0] refm [NR][NC];

    always #(CLK_P/2) clk = ~clk;

    dtm_core #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DW(DW)) uut (
        .clk(clk), .rst(rst), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
        .tm_active(tm_active), .rfsh_row(rfsh_row)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input int r, input int c, input logic [7:0] v);
        addr = AW'(r); ras_n = 1'b0; tick(1);
        addr = AW'(c); we_n = 1'b0; oe_n = 1'b0; dq_in = v; cas_n = 1'b0; tick(1);
        check("R10 early write no drive", dq_oe, 0);
        cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; tick(1);
        ras_n = 1'b1; tick(1);
    endtask

    task automatic do_read(input int r, input int c, input logic oe_lvl,
                           output logic oe1, output logic [7:0] d1,
                           output logic oe2, output logic [7:0] d2);
        addr = AW'(r); ras_n = 1'b0; tick(1);
        addr = AW'(c); oe_n = oe_lvl; cas_n = 1'b0; tick(1);
        oe1 = dq_oe; d1 = dq_out; tick(1);
        oe2 = dq_oe; d2 = dq_out;
        cas_n = 1'b1; tick(1);
        check("R10 cas high no drive", dq_oe, 0);
        oe_n = 1'b1; ras_n = 1'b1; tick(1);
    endtask

    task automatic do_refresh(input logic wel);
        cas_n = 1'b0; we_n = wel; tick(1);
        ras_n = 1'b0; tick(2);
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; tick(2);
        rc = (rc + 1) % NR;
    endtask

    task automatic do_ras_only(input int r);
        addr = AW'(r); ras_n = 1'b0; tick(2);
        ras_n = 1'b1; tick(2);
    endtask

    task automatic full_normal_readback(input string tag);
        logic o1, o2;
        logic [7:0] d1, d2;
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) begin
                do_read(r, c, 1'b0, o1, d1, o2, d2);
                check({tag, " oe"}, o1, 1);
                check({tag, " data"}, d1, refm[r][c]);
                check({tag, " hold"}, d2, refm[r][c]);
            end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic o1, o2;
        logic [7:0] d1, d2;
        logic [7:0] ex;
        tick(3);
        check("R1 tm at reset", tm_active, 0);
        check("R1 oe at reset", dq_oe, 0);
        check("R1 counter at reset", rfsh_row, 0);
        rst = 1'b0;
        tick(1);
        check("R1 tm after reset", tm_active, 0);

        // Fill array in normal mode; pairs differ by a varying mask
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) begin
                if (c < HC) refm[r][c] = 8'((r * 16 + c * 7 + 8'h3C) & 8'hFF);
                else        refm[r][c] = refm[r][c-HC] ^ 8'(((c * 37) + (r * 5)) & 8'hFF);
                do_write(r, c, refm[r][c]);
            end
        full_normal_readback("R6 normal read");

        do_read(1, 3, 1'b1, o1, d1, o2, d2);
        check("R10 oe_n high first", o1, 0);
        check("R10 oe_n high second", o2, 0);

        // Enter test mode
        do_refresh(1'b0);
        check("R2 tm set", tm_active, 1);
        check("R2 counter step", rfsh_row, rc);

        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) begin
                ex = ~(refm[r][c % HC] ^ refm[r][(c % HC) + HC]);
                do_read(r, c, 1'b0, o1, d1, o2, d2);
                check("R9 first edge quiet", o1, 0);
                check("R9 second edge drives", o2, 1);
                check("R8 compressed data", d2, ex);
            end
        check("R3 tm held over reads", tm_active, 1);

        for (int r = 0; r < NR; r++) begin
            int c;
            c = HC + ((r * 3) % HC);
            ex = 8'((8'hA5 + r * 19) & 8'hFF);
            do_write(r, c, ex);
            refm[r][c] = ex;
            refm[r][c - HC] = ex;
            do_read(r, c - HC, 1'b0, o1, d1, o2, d2);
            check("R7 pair equal after write", d2, 8'hFF);
        end
        check("R3 tm held over writes", tm_active, 1);
        check("R2 counter unchanged by access", rfsh_row, rc);

        // Exit with plain refresh
        do_refresh(1'b1);
        check("R4 tm cleared", tm_active, 0);
        check("R4 counter step", rfsh_row, rc);
        full_normal_readback("R7 R11 readback");

        // Enter again, exit by row-only cycle
        do_refresh(1'b0);
        check("R2 tm set again", tm_active, 1);
        do_ras_only(2);
        check("R5 tm cleared by row-only", tm_active, 0);
        check("R5 counter unchanged", rfsh_row, rc);

        // Counter wraps
        do_refresh(1'b1);
        check("R4 counter wrap", rfsh_row, rc);
        check("R4 tm stays clear", tm_active, 0);
        do_read(3, 9, 1'b0, o1, d1, o2, d2);
        check("R11 data after refreshes", d1, refm[3][9]);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule